// File: doc/BRIEF.md
# USB Port Suspend and Resume Controller

This block holds the low-power control state of a single USB port: the suspend bit, the force-resume bit and the over-current-change flag. Software changes them with a one-cycle register write strobe, and hardware sequences them from the port's line state and its control flags. In host mode, software requests suspend. If a transaction is in progress, the request waits until it ends. Hardware then drives and times the resume and clears both bits when the timing is done. In device mode, the suspend bit is status only. It is set when the line has idled in J for a programmable time. Software may start a remote wakeup only once the port has stayed suspended for a qualification period.

A J-to-K transition on the line while the port is suspended moves the port into resume on its own and raises a one-cycle port-change pulse. All timings are parameters in clock cycles. The line drivers, packet engine and chirp logic are outside the block. They consume `drive_k_o` and supply `line_state_i`, `txn_active_i` and the port flags.

Top module: `usb_port_sleep_ctrl`

## Requirements
- R1: While `rst_ni` is low, and on the first cycle after it is released, every output is 0.
- R2: A write carries three bits: bit 0 requests suspend, bit 1 requests force-resume, and bit 2 clears the over-current-change flag. In host mode with the port enabled, a suspend request makes `suspend_o` 1 after the next clock edge when no transaction is in progress. If a transaction is in progress, `suspend_o` stays 0 until the edge that sees `txn_active_i` low, and becomes 1 after that edge.
- R3: A write with bit 0 clear never changes the suspend state. A suspend request made while `port_en_i` is 0 is dropped and leaves `suspend_o` at 0.
- R4: Line state encoding is 00 SE0, 01 J, 10 K, 11 SE1. While suspended, a line sample of J followed by a sample of K raises `force_resume_o` and a one-cycle `port_change_o` on the same edge. That edge is the second rising edge after the input changes to K.
- R5: In host mode, a force-resume request while suspended raises `force_resume_o`. `drive_k_o` is 1 exactly while `force_resume_o` is 1. A write of 0 to the force-resume bit does not clear it. A software-started resume raises no `port_change_o`.
- R6: In host mode, `force_resume_o` stays 1 for RESUME_CYC+1 cycles. It then clears on the same edge as `suspend_o`. `suspend_o` never falls after `force_resume_o`.
- R7: In host mode, when `port_power_i` is 0, `suspend_o` and `force_resume_o` are 0 from the next clock edge onward.
- R8: In device mode, a suspend request has no effect. `suspend_o` rises on the (IDLE_CYC+2)-th rising edge after `line_state_i` becomes J and stays J.
- R9: In device mode, `susp_qual_o` rises QUAL_CYC cycles after `suspend_o`. A force-resume request made before then is ignored. After then it is accepted and `drive_k_o` is 1 for WAKE_CYC cycles.
- R10: In device mode, `force_resume_o` and `suspend_o` clear together on the second edge after the line leaves K, but only once any self-driven K has ended. A resume started by the host never raises `drive_k_o`.
- R11: `oc_change_o` is set on the edge after any change of `oc_active_i`. A write with bit 2 set clears it. A change on the same edge wins over the clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | One-cycle register write strobe |
| wr_data_i | input | 3 | Write data: [0] suspend, [1] force-resume, [2] over-current-change clear |
| host_mode_i | input | 1 | 1 = host mode, 0 = device mode |
| port_en_i | input | 1 | Port enabled flag |
| port_power_i | input | 1 | Port power flag |
| txn_active_i | input | 1 | A bus transaction is in progress |
| line_state_i | input | 2 | Sampled line state |
| oc_active_i | input | 1 | Over-current active level |
| suspend_o | output | 1 | Suspend status |
| force_resume_o | output | 1 | Force-resume status |
| oc_change_o | output | 1 | Over-current change flag |
| susp_qual_o | output | 1 | Device has been suspended long enough to wake the host |
| drive_k_o | output | 1 | Drive K signaling on the line |
| port_change_o | output | 1 | One-cycle pulse on a detected J-to-K resume |

## Verification
Suspend entry is tried three ways in host mode: with the bus idle, with a transaction in flight across several cycles, and with the port disabled or a zero written. Together these separate immediate entry, deferred entry and dropped requests. Resume is started from the line, by a J-then-K sequence, and by software in both modes. This separates the port-change pulse, the self-driven K length, the host-timed RESUME_CYC+1 window, and the device exit that waits for the line to leave K. A vector table steps the over-current input and the clear bit through changes, holds and coincident change-and-clear, so set-wins priority is told apart from plain write-1-to-clear.

// File: rtl/usb_ssr_pkg.sv
package usb_ssr_pkg;
  typedef enum logic [1:0] {
    PS_ACTIVE    = 2'd0,
    PS_SUSP_WAIT = 2'd1,
    PS_SUSPENDED = 2'd2,
    PS_RESUMING  = 2'd3
  } port_st_e;

  localparam logic [1:0] LS_SE0 = 2'b00;
  localparam logic [1:0] LS_J   = 2'b01;
  localparam logic [1:0] LS_K   = 2'b10;

  localparam int unsigned WR_W    = 3;
  localparam int unsigned WB_SUSP = 0;
  localparam int unsigned WB_FRES = 1;
  localparam int unsigned WB_OCC  = 2;
endpackage

// File: rtl/usb_ssr_line_mon.sv
module usb_ssr_line_mon
  import usb_ssr_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic [1:0] line_i,
  output logic       is_j_o,
  output logic       is_k_o,
  output logic       jk_evt_o
);
  logic [1:0] cur_q, prv_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cur_q <= LS_SE0;
      prv_q <= LS_SE0;
    end else begin
      prv_q <= cur_q;
      cur_q <= line_i;
    end
  end

  assign is_j_o   = (cur_q == LS_J);
  assign is_k_o   = (cur_q == LS_K);
  assign jk_evt_o = (prv_q == LS_J) && (cur_q == LS_K);
endmodule

// File: rtl/usb_ssr_cyc_timer.sv
module usb_ssr_cyc_timer #(
  parameter int unsigned W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         en_i,
  input  logic [W-1:0] limit_i,
  output logic         done_o
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                cnt_q <= '0;
    else if (!en_i)             cnt_q <= '0;
    else if (cnt_q != limit_i)  cnt_q <= cnt_q + 1'b1;
  end

  assign done_o = en_i && (cnt_q == limit_i);
endmodule

// File: rtl/usb_ssr_port_fsm.sv
module usb_ssr_port_fsm
  import usb_ssr_pkg::*;
(
  input  logic     clk_i,
  input  logic     rst_ni,
  input  logic     host_i,
  input  logic     power_i,
  input  logic     enable_i,
  input  logic     txn_i,
  input  logic     set_susp_i,
  input  logic     set_fres_i,
  input  logic     jk_evt_i,
  input  logic     line_k_i,
  input  logic     idle_done_i,
  input  logic     qual_done_i,
  input  logic     res_done_i,
  output port_st_e state_o,
  output logic     wake_o,
  output logic     chg_o
);
  port_st_e st_q, st_d;
  logic     wake_q, wake_d;
  logic     chg_q, chg_d;

  always_comb begin
    st_d   = st_q;
    wake_d = wake_q;
    chg_d  = 1'b0;
    case (st_q)
      PS_ACTIVE: begin
        if (host_i) begin
          if (set_susp_i && enable_i) st_d = txn_i ? PS_SUSP_WAIT : PS_SUSPENDED;
        end else if (idle_done_i) begin
          st_d = PS_SUSPENDED;
        end
      end
      PS_SUSP_WAIT: begin
        if (!host_i)     st_d = PS_ACTIVE;
        else if (!txn_i) st_d = PS_SUSPENDED;
      end
      PS_SUSPENDED: begin
        if (jk_evt_i) begin
          st_d   = PS_RESUMING;
          wake_d = 1'b0;
          chg_d  = 1'b1;
        end else if (set_fres_i && (host_i || qual_done_i)) begin
          st_d   = PS_RESUMING;
          wake_d = 1'b1;
        end
      end
      PS_RESUMING: begin
        // host: hardware-timed; device: wait for own K to end and line to leave K
        if (host_i) begin
          if (res_done_i) st_d = PS_ACTIVE;
        end else if ((!wake_q || res_done_i) && !line_k_i) begin
          st_d = PS_ACTIVE;
        end
      end
      default: st_d = PS_ACTIVE;
    endcase
    if (st_d == PS_ACTIVE) wake_d = 1'b0;
    if (host_i && !power_i) begin
      st_d   = PS_ACTIVE;
      wake_d = 1'b0;
      chg_d  = 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= PS_ACTIVE;
      wake_q <= 1'b0;
      chg_q  <= 1'b0;
    end else begin
      st_q   <= st_d;
      wake_q <= wake_d;
      chg_q  <= chg_d;
    end
  end

  assign state_o = st_q;
  assign wake_o  = wake_q;
  assign chg_o   = chg_q;
endmodule

// File: rtl/usb_port_sleep_ctrl.sv
module usb_port_sleep_ctrl
  import usb_ssr_pkg::*;
#(
  parameter int unsigned RESUME_CYC = 1_200_000, // 20 ms at 60 MHz
  parameter int unsigned WAKE_CYC   = 600_000,   // 10 ms
  parameter int unsigned QUAL_CYC   = 300_000,   // 5 ms
  parameter int unsigned IDLE_CYC   = 180_000    // 3 ms
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            wr_en_i,
  input  logic [WR_W-1:0] wr_data_i,
  input  logic            host_mode_i,
  input  logic            port_en_i,
  input  logic            port_power_i,
  input  logic            txn_active_i,
  input  logic [1:0]      line_state_i,
  input  logic            oc_active_i,
  output logic            suspend_o,
  output logic            force_resume_o,
  output logic            oc_change_o,
  output logic            susp_qual_o,
  output logic            drive_k_o,
  output logic            port_change_o
);
  localparam int unsigned RES_MAX = (RESUME_CYC > WAKE_CYC) ? RESUME_CYC : WAKE_CYC;
  localparam int unsigned RES_W   = $clog2(RES_MAX + 1);
  localparam int unsigned QUAL_W  = $clog2(QUAL_CYC + 1);
  localparam int unsigned IDLE_W  = $clog2(IDLE_CYC + 1);

  logic set_susp, set_fres, occ_clr;
  logic is_j, is_k, jk_evt;
  logic idle_done, qual_done, res_done;
  logic wake, chg;
  port_st_e st;
  logic [RES_W-1:0] res_lim;
  logic oc_q, occ_q;

  assign set_susp = wr_en_i && wr_data_i[WB_SUSP];
  assign set_fres = wr_en_i && wr_data_i[WB_FRES];
  assign occ_clr  = wr_en_i && wr_data_i[WB_OCC];

  usb_ssr_line_mon i_line (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .line_i   (line_state_i),
    .is_j_o   (is_j),
    .is_k_o   (is_k),
    .jk_evt_o (jk_evt)
  );

  assign res_lim = host_mode_i ? RES_W'(RESUME_CYC) : RES_W'(WAKE_CYC);

  usb_ssr_cyc_timer #(.W(RES_W)) i_res_tmr (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .en_i    (st == PS_RESUMING),
    .limit_i (res_lim),
    .done_o  (res_done)
  );

  usb_ssr_cyc_timer #(.W(QUAL_W)) i_qual_tmr (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .en_i    (!host_mode_i && (st == PS_SUSPENDED)),
    .limit_i (QUAL_W'(QUAL_CYC)),
    .done_o  (qual_done)
  );

  usb_ssr_cyc_timer #(.W(IDLE_W)) i_idle_tmr (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .en_i    (!host_mode_i && (st == PS_ACTIVE) && is_j),
    .limit_i (IDLE_W'(IDLE_CYC)),
    .done_o  (idle_done)
  );

  usb_ssr_port_fsm i_fsm (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .host_i      (host_mode_i),
    .power_i     (port_power_i),
    .enable_i    (port_en_i),
    .txn_i       (txn_active_i),
    .set_susp_i  (set_susp),
    .set_fres_i  (set_fres),
    .jk_evt_i    (jk_evt),
    .line_k_i    (is_k),
    .idle_done_i (idle_done),
    .qual_done_i (qual_done),
    .res_done_i  (res_done),
    .state_o     (st),
    .wake_o      (wake),
    .chg_o       (chg)
  );

  // over-current change: a fresh edge wins over a same-cycle clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      oc_q  <= 1'b0;
      occ_q <= 1'b0;
    end else begin
      oc_q <= oc_active_i;
      if (oc_active_i != oc_q) occ_q <= 1'b1;
      else if (occ_clr)        occ_q <= 1'b0;
    end
  end

  assign suspend_o      = (st == PS_SUSPENDED) || (st == PS_RESUMING);
  assign force_resume_o = (st == PS_RESUMING);
  assign oc_change_o    = occ_q;
  assign susp_qual_o    = qual_done;
  assign drive_k_o      = (st == PS_RESUMING) && (host_mode_i || (wake && !res_done));
  assign port_change_o  = chg;
endmodule

// File: rtl/usb_port_sleep_ctrl_chk.sv
module usb_port_sleep_ctrl_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic host_mode_i,
  input logic port_power_i,
  input logic txn_active_i,
  input logic oc_active_i,
  input logic suspend_o,
  input logic force_resume_o,
  input logic oc_change_o,
  input logic susp_qual_o,
  input logic drive_k_o,
  input logic port_change_o
);
  p_txn_defer_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    host_mode_i && txn_active_i && !suspend_o |=> !suspend_o);

  p_chg_with_fres_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    port_change_o |-> $rose(force_resume_o));

  p_chg_single_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    port_change_o |=> !port_change_o);

  p_fres_from_susp_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(force_resume_o) |-> $past(suspend_o));

  p_host_drive_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    host_mode_i |-> (drive_k_o == force_resume_o));

  p_fres_in_susp_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    force_resume_o |-> suspend_o);

  p_susp_drop_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(force_resume_o) |-> !suspend_o);

  p_power_off_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    host_mode_i && !port_power_i |=> !suspend_o && !force_resume_o);

  p_qual_first_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !host_mode_i && $rose(force_resume_o) && !port_change_o |-> $past(susp_qual_o));

  p_dev_drive_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    drive_k_o |-> force_resume_o);

  p_oc_set_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(oc_active_i) |=> oc_change_o);
endmodule

bind usb_port_sleep_ctrl usb_port_sleep_ctrl_chk i_chk (
  .clk_i          (clk_i),
  .rst_ni         (rst_ni),
  .host_mode_i    (host_mode_i),
  .port_power_i   (port_power_i),
  .txn_active_i   (txn_active_i),
  .oc_active_i    (oc_active_i),
  .suspend_o      (suspend_o),
  .force_resume_o (force_resume_o),
  .oc_change_o    (oc_change_o),
  .susp_qual_o    (susp_qual_o),
  .drive_k_o      (drive_k_o),
  .port_change_o  (port_change_o)
);

// File: tb/test_usb_port_sleep_ctrl.sv
module test_usb_port_sleep_ctrl;
  localparam int unsigned RES_C  = 30;
  localparam int unsigned WAKE_C = 12;
  localparam int unsigned QUAL_C = 20;
  localparam int unsigned IDLE_C = 16;

  // {oc_active, clear bit, expected flag}
  localparam logic [2:0] OCC_VEC [8] = '{
    3'b000, 3'b101, 3'b101, 3'b110, 3'b100, 3'b001, 3'b111, 3'b110
  };

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [2:0] wr_data = 3'b000;
  logic       host = 1'b1;
  logic       pen = 1'b1;
  logic       pwr = 1'b1;
  logic       txn = 1'b0;
  logic [1:0] line = 2'b01;
  logic       oc = 1'b0;
  logic       susp, fres, occ, qual, dk, pchg;

  int total = 0;
  int bad = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  usb_port_sleep_ctrl #(
    .RESUME_CYC (RES_C),
    .WAKE_CYC   (WAKE_C),
    .QUAL_CYC   (QUAL_C),
    .IDLE_CYC   (IDLE_C)
  ) i_usb_port_sleep_ctrl (
    .clk_i          (clk),
    .rst_ni         (rst_n),
    .wr_en_i        (wr_en),
    .wr_data_i      (wr_data),
    .host_mode_i    (host),
    .port_en_i      (pen),
    .port_power_i   (pwr),
    .txn_active_i   (txn),
    .line_state_i   (line),
    .oc_active_i    (oc),
    .suspend_o      (susp),
    .force_resume_o (fres),
    .oc_change_o    (occ),
    .susp_qual_o    (qual),
    .drive_k_o      (dk),
    .port_change_o  (pchg)
  );

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic check(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] d);
    wr_en = 1'b1;
    wr_data = d;
    tick();
    wr_en = 1'b0;
    wr_data = 3'b000;
  endtask

  task automatic do_reset(input logic h, input logic [1:0] ls);
    rst_n = 1'b0;
    host = h;
    line = ls;
    repeat (3) tick();
    check("R1 reset outputs", int'({susp, fres, occ, qual, dk, pchg}), 0);
    rst_n = 1'b1;
    tick();
    check("R1 after release", int'({susp, fres, occ, qual, dk, pchg}), 0);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      bad++;
      total++;
      $display("FAIL watchdog: actual=timeout expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int n;
    do_reset(1'b1, 2'b01);

    // OCC vector table, R11
    for (int i = 0; i < 8; i++) begin
      oc = OCC_VEC[i][2];
      wr_en = OCC_VEC[i][1];
      wr_data = {OCC_VEC[i][1], 2'b00};
      tick();
      check("R11 occ vector", int'(occ), int'(OCC_VEC[i][0]));
    end
    wr_en = 1'b0;
    wr_data = 3'b000;
    oc = 1'b0;
    tick();
    wr(3'b100);

    // R3: zero write and disabled port
    wr(3'b000);
    check("R3 write zero", int'(susp), 0);
    pen = 1'b0;
    wr(3'b001);
    check("R3 disabled", int'(susp), 0);
    pen = 1'b1;
    tick();
    check("R3 dropped", int'(susp), 0);

    // R2: deferred suspend
    txn = 1'b1;
    wr(3'b001);
    check("R2 deferred", int'(susp), 0);
    repeat (3) tick();
    check("R2 still deferred", int'(susp), 0);
    txn = 1'b0;
    tick();
    check("R2 suspended", int'(susp), 1);

    // R4: J-to-K while suspended
    line = 2'b10;
    tick();
    check("R4 one edge", int'(fres), 0);
    tick();
    check("R4 fres", int'(fres), 1);
    check("R4 pchg", int'(pchg), 1);
    check("R5 drive k", int'(dk), 1);
    line = 2'b01;
    wr(3'b000);
    check("R5 zero write", int'(fres), 1);
    check("R4 pulse width", int'(pchg), 0);
    n = 2;
    for (int k = 0; k < 100; k++) begin
      tick();
      if (fres) n++;
      else break;
    end
    check("R6 resume length", n, RES_C + 1);
    check("R6 suspend cleared", int'(susp), 0);
    check("R5 drive off", int'(dk), 0);

    // R2 immediate, R5 software resume, R7 power
    wr(3'b001);
    check("R2 immediate", int'(susp), 1);
    wr(3'b010);
    check("R5 sw resume", int'(fres), 1);
    check("R5 sw drive", int'(dk), 1);
    check("R5 no pchg", int'(pchg), 0);
    pwr = 1'b0;
    tick();
    check("R7 susp off", int'(susp), 0);
    check("R7 fres off", int'(fres), 0);
    pwr = 1'b1;
    tick();
    check("R7 stays", int'({susp, fres}), 0);

    // device: R8 idle entry, R9 qualification, R10 exit
    do_reset(1'b0, 2'b00);
    wr(3'b001);
    check("R8 read only", int'(susp), 0);
    line = 2'b01;
    repeat (IDLE_C + 1) tick();
    check("R8 before idle", int'(susp), 0);
    tick();
    check("R8 idle suspend", int'(susp), 1);
    repeat (QUAL_C - 1) tick();
    check("R9 not qualified", int'(qual), 0);
    wr(3'b010);
    check("R9 early ignored", int'(fres), 0);
    check("R9 qualified", int'(qual), 1);
    wr(3'b010);
    check("R9 wake accepted", int'(fres), 1);
    check("R9 pchg quiet", int'(pchg), 0);
    line = 2'b10;
    n = dk ? 1 : 0;
    for (int k = 0; k < 100; k++) begin
      tick();
      if (dk) n++;
      else break;
    end
    check("R9 wake length", n, WAKE_C);
    check("R10 held in K", int'(fres), 1);
    line = 2'b00;
    tick();
    check("R10 one edge", int'(fres), 1);
    tick();
    check("R10 fres clear", int'(fres), 0);
    check("R10 susp clear", int'(susp), 0);

    // device: host-initiated resume
    do_reset(1'b0, 2'b00);
    line = 2'b01;
    repeat (IDLE_C + 2) tick();
    check("R8 suspended again", int'(susp), 1);
    line = 2'b10;
    repeat (2) tick();
    check("R4 dev fres", int'(fres), 1);
    check("R4 dev pchg", int'(pchg), 1);
    check("R10 no self drive", int'(dk), 0);
    line = 2'b00;
    tick();
    check("R10 dev held", int'(fres), 1);
    tick();
    check("R10 dev exit", int'({susp, fres}), 0);

    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule